// File: doc/BRIEF.md
# Dual-Tone Quadrature Sine Synthesizer

This block is the tone source for a spread-frequency-shift-keying modem. It keeps two phase accumulators, one for the mark tone (data 1) and one for the space tone (data 0). Each accumulator advances by its own programmable 16-bit step every time the sample strobe fires. The upper bits of each phase address a quarter-wave sine table and reach the full circle through quadrant symmetry. The cosine is read at the same phase plus a quarter turn.

In transmit mode the block emits one sine stream. The current data bit chooses whether that stream carries the mark tone or the space tone. Both accumulators keep running in either mode, so a change of data bit switches to a tone that has stayed phase-continuous. In receive mode the block emits sine and cosine samples for both tones at once, for use by a downstream quadrature mixer. The step values are loaded through a simple processor write port.

Top module: `dds_dual_tone`

## Requirements
- R1: A write (`wr_en`=1) loads `wr_data` into the mark step register when `wr_sel`=1 and into the space step register when `wr_sel`=0. The new value is used by the advances on strobes after the write cycle, and an advance in the same cycle as the write still uses the old step.
- R2: Each tone has a 16-bit phase that grows by its step on every cycle with `smp_en`=1 and wraps modulo 65536. The first strobe after reset reports phase 0, and strobe n reports phase n times step (mod 65536).
- R3: A sample taken at phase P is a 12-bit two's complement value within ±1 of round(2047·sin(2π·(P[15:8]+0.5)/256)). Its magnitude never exceeds 2047.
- R4: In transmit mode (`rx_mode`=0), `tx_sample` carries the mark sine when `tx_bit`=1 and the space sine when `tx_bit`=0. The four quadrature outputs read 0.
- R5: In receive mode (`rx_mode`=1), `mark_i`/`space_i` carry the sine at each tone's phase and `mark_q`/`space_q` carry the sample at that phase plus 0x4000 (cosine). `tx_sample` reads 0.
- R6: `smp_valid` is 1 in exactly the cycle after each strobe cycle and 0 otherwise.
- R7: Without a strobe, the outputs hold their values and neither phase advances.
- R8: Both phases advance on every strobe, in either mode and for either value of `tx_bit`, so each tone stays phase-continuous across bit and mode changes.
- R9: `rst_n`=0 clears both step registers, both phases, all sample outputs and `smp_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Step register write strobe |
| wr_sel | input | 1 | Step register select: 1 mark, 0 space |
| wr_data | input | 16 | Step value to load |
| rx_mode | input | 1 | 1 receive (quadrature), 0 transmit |
| tx_bit | input | 1 | Data bit choosing the transmit tone |
| smp_en | input | 1 | Sample strobe: take a sample and advance phases |
| tx_sample | output | 12 | Transmit sine sample |
| mark_i | output | 12 | Mark tone sine |
| mark_q | output | 12 | Mark tone cosine |
| space_i | output | 12 | Space tone sine |
| space_q | output | 12 | Space tone cosine |
| smp_valid | output | 1 | One-cycle flag for new samples |

## Verification
On every cycle the assertions check that the valid flag follows the strobe by exactly one cycle, that outputs hold between strobes, that each mode silences the outputs it does not use, and that no sample ever reaches the most negative code. The waveform values themselves can only be shown by the bench's scenarios. These are the table-driven sine values, the quarter-turn cosine offset, the wrap of the phase, a step written in the same cycle as a strobe, and the phase continuity of both tones across bit and mode switches, all compared against an independent phase model.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int unsigned DDS_PH_W   = 16;
  localparam int unsigned DDS_ADDR_W = 8;
  localparam int unsigned DDS_SMP_W  = 12;

  typedef enum logic {
    TONE_SPACE = 1'b0,
    TONE_MARK  = 1'b1
  } tone_e;
endpackage

// File: rtl/dds_step_acc.sv
module dds_step_acc #(
  parameter int unsigned PH_W = dds_pkg::DDS_PH_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [PH_W-1:0] wr_data,
  input  logic            adv,
  output logic [PH_W-1:0] phase
);
  logic [PH_W-1:0] step_q, step_d;
  logic [PH_W-1:0] phase_q, phase_d;

  always_comb begin
    step_d  = wr_en ? wr_data : step_q;
    phase_d = adv ? (phase_q + step_q) : phase_q;  // wraps modulo 2^PH_W
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= '0;
      phase_q <= '0;
    end else begin
      if (wr_en) step_q  <= step_d;
      if (adv)   phase_q <= phase_d;
    end
  end

  assign phase = phase_q;
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int unsigned ADDR_W = dds_pkg::DDS_ADDR_W,
  parameter int unsigned SMP_W  = dds_pkg::DDS_SMP_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SMP_W-1:0]  sample
);
  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam int unsigned QN    = 1 << IDX_W;
  localparam longint      AMP   = (longint'(1) << (SMP_W - 1)) - 1;
  localparam longint      SCL   = longint'(1) << 30;
  localparam longint      PI_SCL = 64'd3373259426;  // pi * 2^30

  // Quarter-wave entry k sits at angle (2k+1)*pi/(4*QN): the half-step
  // offset lets the mirrored quadrant use a plain bit inversion of k.
  function automatic logic [SMP_W-2:0] quarter_sine(input int k);
    longint x, term, acc;
    x    = (longint'(2 * k + 1) * PI_SCL) / longint'(4 * QN);
    term = x;
    acc  = x;
    for (int n = 1; n < 10; n++) begin
      term = (term * x) / SCL;
      term = (term * x) / SCL;
      term = -term / longint'((2 * n) * (2 * n + 1));
      acc  = acc + term;
    end
    return (SMP_W-1)'((acc * AMP + SCL / 2) / SCL);
  endfunction

  logic [SMP_W-2:0] rom [QN];

  for (genvar k = 0; k < QN; k++) begin : g_rom
    localparam logic [SMP_W-2:0] ENTRY = quarter_sine(k);
    assign rom[k] = ENTRY;
  end

  logic             neg_half;
  logic             mirror;
  logic [IDX_W-1:0] idx;
  logic [SMP_W-2:0] mag;

  always_comb begin
    neg_half = addr[ADDR_W-1];
    mirror   = addr[ADDR_W-2];
    idx      = mirror ? ~addr[IDX_W-1:0] : addr[IDX_W-1:0];
    mag      = rom[idx];
    sample   = neg_half ? (SMP_W)'(-$signed({1'b0, mag})) : {1'b0, mag};
  end
endmodule

// File: rtl/dds_dual_tone.sv
module dds_dual_tone #(
  parameter int unsigned PH_W   = dds_pkg::DDS_PH_W,
  parameter int unsigned ADDR_W = dds_pkg::DDS_ADDR_W,
  parameter int unsigned SMP_W  = dds_pkg::DDS_SMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [PH_W-1:0]  wr_data,
  input  logic             rx_mode,
  input  logic             tx_bit,
  input  logic             smp_en,
  output logic [SMP_W-1:0] tx_sample,
  output logic [SMP_W-1:0] mark_i,
  output logic [SMP_W-1:0] mark_q,
  output logic [SMP_W-1:0] space_i,
  output logic [SMP_W-1:0] space_q,
  output logic             smp_valid
);
  import dds_pkg::*;

  localparam int unsigned N_TONE = 2;
  localparam int unsigned N_LUT  = 2 * N_TONE;  // sine and cosine per tone
  localparam int unsigned QTR    = 1 << (ADDR_W - 2);

  logic [PH_W-1:0]  phase [N_TONE];
  logic [SMP_W-1:0] lut_out [N_LUT];  // index = tone*2 + (1 for cosine)

  for (genvar t = 0; t < N_TONE; t++) begin : g_tone
    dds_step_acc #(.PH_W(PH_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en && (wr_sel == 1'(t))),
      .wr_data (wr_data),
      .adv     (smp_en),
      .phase   (phase[t])
    );
  end

  for (genvar j = 0; j < N_LUT; j++) begin : g_lut
    localparam logic [ADDR_W-1:0] OFS = (j % 2 == 1) ? ADDR_W'(QTR) : '0;
    logic [ADDR_W-1:0] addr;
    assign addr = phase[j / 2][PH_W-1 -: ADDR_W] + OFS;
    dds_sine_rom #(.ADDR_W(ADDR_W), .SMP_W(SMP_W)) u_rom (
      .addr   (addr),
      .sample (lut_out[j])
    );
  end

  localparam int unsigned SP_I = 2 * TONE_SPACE;
  localparam int unsigned SP_Q = 2 * TONE_SPACE + 1;
  localparam int unsigned MK_I = 2 * TONE_MARK;
  localparam int unsigned MK_Q = 2 * TONE_MARK + 1;

  logic [SMP_W-1:0] tx_d, mi_d, mq_d, si_d, sq_d;
  logic [SMP_W-1:0] tx_q, mi_q, mq_q, si_q, sq_q;
  logic             vld_q;

  always_comb begin
    if (rx_mode) begin
      tx_d = '0;
      mi_d = lut_out[MK_I];
      mq_d = lut_out[MK_Q];
      si_d = lut_out[SP_I];
      sq_d = lut_out[SP_Q];
    end else begin
      tx_d = tx_bit ? lut_out[MK_I] : lut_out[SP_I];
      mi_d = '0;
      mq_d = '0;
      si_d = '0;
      sq_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      mi_q  <= '0;
      mq_q  <= '0;
      si_q  <= '0;
      sq_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= smp_en;
      if (smp_en) begin
        tx_q <= tx_d;
        mi_q <= mi_d;
        mq_q <= mq_d;
        si_q <= si_d;
        sq_q <= sq_d;
      end
    end
  end

  assign tx_sample = tx_q;
  assign mark_i    = mi_q;
  assign mark_q    = mq_q;
  assign space_i   = si_q;
  assign space_q   = sq_q;
  assign smp_valid = vld_q;
endmodule

// File: rtl/dds_dual_tone_chk.sv
module dds_dual_tone_chk #(
  parameter int unsigned PH_W   = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SMP_W  = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [PH_W-1:0]  wr_data,
  input logic             rx_mode,
  input logic             tx_bit,
  input logic             smp_en,
  input logic [SMP_W-1:0] tx_sample,
  input logic [SMP_W-1:0] mark_i,
  input logic [SMP_W-1:0] mark_q,
  input logic [SMP_W-1:0] space_i,
  input logic [SMP_W-1:0] space_q,
  input logic             smp_valid
);
  localparam logic [SMP_W-1:0] MOST_NEG = {1'b1, {(SMP_W-1){1'b0}}};

  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en |=> smp_valid);
  a_r6_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> !smp_valid);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> ($stable(tx_sample) && $stable(mark_i) && $stable(mark_q)
                 && $stable(space_i) && $stable(space_q)));
  a_r4_tx_quad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && !rx_mode) |=> (mark_i == '0 && mark_q == '0
                              && space_i == '0 && space_q == '0));
  a_r5_rx_tx_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && rx_mode) |=> (tx_sample == '0));
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (tx_sample != MOST_NEG && mark_i != MOST_NEG && mark_q != MOST_NEG
                   && space_i != MOST_NEG && space_q != MOST_NEG));
endmodule

bind dds_dual_tone dds_dual_tone_chk #(.PH_W(PH_W), .ADDR_W(ADDR_W), .SMP_W(SMP_W)) u_chk (.*);

// File: tb/dds_dual_tone_tb.sv
`timescale 1ns/1ps
module dds_dual_tone_tb_top;
  localparam int unsigned PH_W  = 16;
  localparam int unsigned SMP_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0, wr_sel = 1'b0;
  logic [PH_W-1:0]  wr_data = '0;
  logic             rx_mode = 1'b0, tx_bit = 1'b0, smp_en = 1'b0;
  logic [SMP_W-1:0] tx_sample, mark_i, mark_q, space_i, space_q;
  logic             smp_valid;

  always #4 clk = ~clk;  // 125 MHz

  dds_dual_tone dut_i (.*);

  int n_run = 0, n_fail = 0;
  logic [15:0] m_ph = '0, s_ph = '0, m_st = '0, s_st = '0;  // bench model

  typedef struct packed {
    logic [15:0] mstep;
    logic [15:0] sstep;
    logic        rx;
    logic        bitv;
    logic [7:0]  n;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{16'h0100, 16'h0200, 1'b0, 1'b1, 8'd20},
    '{16'h0100, 16'h0200, 1'b0, 1'b0, 8'd20},
    '{16'h0333, 16'h0155, 1'b1, 1'b0, 8'd24},
    '{16'h1000, 16'h0C00, 1'b0, 1'b1, 8'd12},
    '{16'h1000, 16'h0C00, 1'b1, 1'b1, 8'd12},
    '{16'h7FFF, 16'h8000, 1'b1, 1'b0, 8'd6},
    '{16'hFFFF, 16'h0001, 1'b0, 1'b0, 8'd8},
    '{16'h2345, 16'h0ABC, 1'b0, 1'b1, 8'd16}
  };

  function automatic int exp_sin(input logic [15:0] ph);
    real a;
    a = 2.0 * 3.14159265358979 * (real'(ph[15:8]) + 0.5) / 256.0;
    return int'(2047.0 * $sin(a));
  endfunction

  task automatic chk_val(input string req, input string nm, input logic [SMP_W-1:0] act, input int exp, input int tol);
    int a, d;
    a = $signed(act);
    d = a - exp;
    n_run++;
    if (d > tol || d < -tol) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, nm, a, exp);
    end
  endtask

  task automatic chk_bit(input string req, input string nm, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, nm, act, exp);
    end
  endtask

  task automatic wr_step(input logic sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (sel) m_st = d; else s_st = d;
  endtask

  // One strobe, optionally with a write in the same cycle; checks all outputs.
  task automatic strobe(input logic wr, input logic sel, input logic [15:0] d);
    @(negedge clk);
    smp_en = 1'b1; wr_en = wr; wr_sel = sel; wr_data = d;
    @(negedge clk);
    smp_en = 1'b0; wr_en = 1'b0;
    chk_bit("R6", "smp_valid after strobe", smp_valid, 1'b1);
    if (rx_mode) begin
      chk_val("R5", "mark_i", mark_i, exp_sin(m_ph), 1);
      chk_val("R5", "mark_q", mark_q, exp_sin(m_ph + 16'h4000), 1);
      chk_val("R5", "space_i", space_i, exp_sin(s_ph), 1);
      chk_val("R5", "space_q", space_q, exp_sin(s_ph + 16'h4000), 1);
      chk_val("R5", "tx_sample zero", tx_sample, 0, 0);
    end else begin
      chk_val("R4", "tx_sample", tx_sample, exp_sin(tx_bit ? m_ph : s_ph), 1);
      chk_val("R4", "mark_i zero", mark_i, 0, 0);
      chk_val("R4", "space_q zero", space_q, 0, 0);
    end
    m_ph = m_ph + m_st;  // R2/R8: both tones advance on every strobe
    s_ph = s_ph + s_st;
    if (wr) begin
      if (sel) m_st = d; else s_st = d;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_ph = '0; s_ph = '0; m_st = '0; s_st = '0;
  endtask

  initial begin
    #(8ns * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R9: reset state
    chk_bit("R9", "smp_valid reset", smp_valid, 1'b0);
    chk_val("R9", "tx_sample reset", tx_sample, 0, 0);
    chk_val("R9", "mark_q reset", mark_q, 0, 0);
    chk_val("R9", "space_i reset", space_i, 0, 0);

    // R2: first strobe after reset reads phase 0 with zero steps
    rx_mode = 1'b1;
    strobe(1'b0, 1'b0, '0);
    chk_val("R2", "first strobe space_i at phase 0", space_i, exp_sin(16'h0000), 1);

    // Table walk: R1 R3 R4 R5 R8 (phases carry over between entries)
    foreach (VEC[i]) begin
      wr_step(1'b1, VEC[i].mstep);
      wr_step(1'b0, VEC[i].sstep);
      rx_mode = VEC[i].rx;
      tx_bit  = VEC[i].bitv;
      for (int k = 0; k < int'(VEC[i].n); k++) strobe(1'b0, 1'b0, '0);
    end

    // R8: toggle tx_bit every strobe, each tone stays phase-continuous
    rx_mode = 1'b0;
    wr_step(1'b1, 16'h0700);
    wr_step(1'b0, 16'h0480);
    for (int k = 0; k < 16; k++) begin
      tx_bit = k[0];
      strobe(1'b0, 1'b0, '0);
    end

    // R7: idle cycles, outputs held, valid low, no phase advance
    begin
      logic [SMP_W-1:0] held;
      held = tx_sample;
      repeat (6) @(negedge clk);
      chk_bit("R6", "smp_valid idle", smp_valid, 1'b0);
      chk_val("R7", "tx_sample held", tx_sample, $signed(held), 0);
      strobe(1'b0, 1'b0, '0);  // model phases unchanged across idle gap
    end

    // R1: write in the same cycle as a strobe uses the old step for that advance
    rx_mode = 1'b1;
    strobe(1'b1, 1'b1, 16'h2000);
    strobe(1'b1, 1'b0, 16'h4000);
    for (int k = 0; k < 6; k++) strobe(1'b0, 1'b0, '0);

    // R2: wrap modulo 65536 with step 0x8000 returns to the start phase
    do_reset();
    wr_step(1'b1, 16'h8000);
    for (int k = 0; k < 5; k++) strobe(1'b0, 1'b0, '0);
    chk_val("R2", "wrap mark_i", mark_i, exp_sin(16'h0000), 1);

    // R9: reset mid-run clears phases and steps
    wr_step(1'b0, 16'h1234);
    repeat (3) strobe(1'b0, 1'b0, '0);
    do_reset();
    chk_bit("R9", "valid after mid reset", smp_valid, 1'b0);
    chk_val("R9", "space_i after mid reset", space_i, 0, 0);
    strobe(1'b0, 1'b0, '0);
    strobe(1'b0, 1'b0, '0);
    chk_val("R9", "steps cleared, space stays at phase 0", space_i, exp_sin(16'h0000), 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule